// File: doc/BRIEF.md
# Half-Bridge Dead-Time Insertion Controller

This block sits between a PWM generator and the two gate-drive paths of a half-bridge. It takes a high-side request and a low-side request and produces gated high-side and low-side drive commands. It applies one of four dead-time policies. Each output is registered, so it follows its request one clock after the request is sampled. All inputs are assumed to be already synchronized to `clk`.

A two-bit `mode` input selects the policy. In blanking mode, any overlap between the two requests is turned into dead-time, and any gap the requests already have is left alone. In programmable mode, an output may not rise until the opposite output has been low for at least the programmed count of clock cycles. The longer of that count and the gap between the requests is what appears at the outputs. Fixed-maximum mode does the same thing with the ceiling count, whatever the program value. Free mode copies each request straight to its output and allows the two outputs to overlap.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: A synchronous active-low reset forces both outputs low and clears the off-time counters. As a result, in programmable mode with a request held high through the reset release, the output first rises on the D-th clock edge after release, where D is the effective dead-time.
- R2: In blanking mode (`mode`=2'b00), an overlap of X cycles between the requests yields X cycles with both outputs low.
- R3: In blanking mode, a gap of G cycles between one request falling and the other rising appears unchanged as G cycles between the output edges.
- R4: In programmable mode (`mode`=2'b01), a request gap shorter than D, including an overlap, is stretched so that the outputs are separated by exactly D cycles.
- R5: In programmable mode, a request gap of G cycles with G at least D is kept as G cycles at the outputs.
- R6: In programmable mode, D equals `dt_prog` clamped to the range 25 to 200.
- R7: In fixed-maximum mode (`mode`=2'b10), D is 200 whatever `dt_prog` holds.
- R8: In free mode (`mode`=2'b11), each output follows its own request, and overlapping requests give both outputs high for the length of the overlap.
- R9: Dead-time applies in both directions, high-to-low and low-to-high.
- R10: An output changes one clock after its request is sampled, and it is high only if its request was high in the previous cycle.
- R11: In every mode other than free mode, the two outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Policy: 00 blanking, 01 programmable, 10 fixed maximum, 11 free |
| dt_prog | input | PROG_W | Programmed dead-time in clock cycles |
| req_hi | input | 1 | High-side request |
| req_lo | input | 1 | Low-side request |
| drv_hi | output | 1 | Gated high-side drive command |
| drv_lo | output | 1 | Gated low-side drive command |

## Verification
The bench uses the default parameters: an 8-bit program value, a floor of 25 and a ceiling of 200. With these, the off-time counter is 8 bits wide and saturates at 255. That lets the bench use program values of 10 and 250 to reach both clamps. It also uses request gaps of 230 cycles to test gaps longer than the ceiling. Overlaps and gaps shorter than the floor cover the stretching in every protected mode. Each case first swings the bridge the opposite way, so dead-time is measured in both directions in every mode.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  typedef enum logic [1:0] {
    HB_BLANK = 2'b00,
    HB_PROG  = 2'b01,
    HB_MAXDT = 2'b10,
    HB_FREE  = 2'b11
  } hb_mode_e;

  // Effective dead-time in cycles for a mode; zero where no timer applies.
  function automatic int hb_eff_dt(logic [1:0] m, int prog, int floor_v, int ceil_v);
    if (m == HB_MAXDT) return ceil_v;
    if (m == HB_PROG) begin
      if (prog < floor_v) return floor_v;
      if (prog > ceil_v) return ceil_v;
      return prog;
    end
    return 0;
  endfunction

endpackage

// File: rtl/hb_off_timer.sv
module hb_off_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          opp_drv,
  output logic [CW-1:0] off_cnt
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic at_top;
  assign at_top = (off_cnt == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)       off_cnt <= '0;
    else if (opp_drv) off_cnt <= '0;
    else if (!at_top) off_cnt <= off_cnt + 1'b1;
  end

  // R1
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(off_cnt) == CMAX && !$past(opp_drv)) |-> off_cnt == CMAX);

endmodule

// File: rtl/hb_side_gate.sv
module hb_side_gate
  import hb_dt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] dt_eff,
  input  logic          req_own,
  input  logic          req_opp,
  input  logic          drv_opp,
  input  logic [CW-1:0] opp_off,
  output logic          drv_own
);
  logic [CW:0] off_plus;
  logic        may_rise;
  logic        excl_req;
  logic        nxt;

  assign off_plus = {1'b0, opp_off} + (CW+1)'(1);
  assign may_rise = (off_plus >= {1'b0, dt_eff}) && !drv_opp;
  assign excl_req = req_own && !req_opp;

  always_comb begin
    case (hb_mode_e'(mode))
      HB_BLANK: nxt = excl_req;
      HB_PROG,
      HB_MAXDT: nxt = excl_req && may_rise;
      default:  nxt = req_own;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drv_own <= 1'b0;
    else        drv_own <= nxt;
  end

  // R10
  drv_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_own |-> $past(req_own));

  // R8
  free_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == 2'b11) |-> drv_own == $past(req_own));

  // R4
  gap_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_own) && ($past(mode) == 2'b01 || $past(mode) == 2'b10))
      |-> !$past(drv_opp));

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_dt_pkg::*;
#(
  parameter int PROG_W   = 8,
  parameter int DT_FLOOR = 25,
  parameter int DT_CEIL  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [PROG_W-1:0] dt_prog,
  input  logic              req_hi,
  input  logic              req_lo,
  output logic              drv_hi,
  output logic              drv_lo
);
  localparam int CW = $clog2(DT_CEIL + 2);

  logic [CW-1:0] dt_eff;
  logic [1:0]    req_v;
  logic [1:0]    drv_v;
  logic [CW-1:0] opp_off_cnt [2];

  assign dt_eff = CW'(hb_eff_dt(mode, int'(dt_prog), DT_FLOOR, DT_CEIL));
  assign req_v  = {req_hi, req_lo};

  // index 1 is the high side, index 0 the low side
  for (genvar s = 0; s < 2; s++) begin : g_side
    hb_off_timer #(.CW(CW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .opp_drv (drv_v[1-s]),
      .off_cnt (opp_off_cnt[s])
    );
    hb_side_gate #(.CW(CW)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .dt_eff  (dt_eff),
      .req_own (req_v[s]),
      .req_opp (req_v[1-s]),
      .drv_opp (drv_v[1-s]),
      .opp_off (opp_off_cnt[s]),
      .drv_own (drv_v[s])
    );
  end

  assign drv_hi = drv_v[1];
  assign drv_lo = drv_v[0];

  // R11
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hi && drv_lo) |-> $past(mode) == 2'b11);

endmodule

// File: tb/test_hb_deadtime_ctrl.sv
module test_hb_deadtime_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [7:0] dt_prog = 8'd40;
  logic       req_hi = 1'b0;
  logic       req_lo = 1'b0;
  logic       drv_hi, drv_lo;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hb_deadtime_ctrl i_hb_deadtime_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dt_prog(dt_prog),
    .req_hi(req_hi), .req_lo(req_lo), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  localparam int NC = 12;
  localparam int TM [NC] = '{0, 0, 1, 1, 1, 1, 1, 2, 2, 3, 3, 1};
  localparam int TP [NC] = '{0, 0, 40, 40, 40, 10, 250, 30, 30, 0, 0, 25};
  localparam int TG [NC] = '{5, -7, 10, 60, -12, 3, 0, 50, 230, 4, -6, 25};

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dead_of(int m, int p);
    if (m == 2) return 200;
    if (m == 1) return (p < 25) ? 25 : ((p > 200) ? 200 : p);
    return 0;
  endfunction

  function automatic string tag_of(int m, int p, int g);
    int a = (g < 0) ? -g : g;
    if (m == 0) return (g < 0) ? "R2 overlap blanked" : "R3 gap kept";
    if (m == 2) return "R7 fixed max";
    if (p < 25 || p > 200) return "R6 clamp";
    return (a < dead_of(m, p)) ? "R4 stretched" : "R5 gap kept";
  endfunction

  task automatic run_case(int m, int p, int g);
    int base = 260;
    int a = (g < 0) ? -g : g;
    int t_lo_fall = (g < 0) ? base - g : base;
    int t_hi_rise = (g < 0) ? base : base + g;
    int lo_fall = -1, hi_rise = -1, hi_fall = -1, lo_rise = -1, both = 0;
    int d = dead_of(m, p);
    int e = (a > d) ? a : d;
    logic ph = 1'b0, pl = 1'b0;
    for (int c = 0; c <= base + a + 260; c++) begin
      @(negedge clk);
      if (c > 0) begin
        if (c <= base) begin
          if (ph && !drv_hi && hi_fall < 0) hi_fall = c;
          if (!pl && drv_lo && lo_rise < 0) lo_rise = c;
        end else begin
          if (pl && !drv_lo && lo_fall < 0) lo_fall = c;
          if (!ph && drv_hi && hi_rise < 0) hi_rise = c;
        end
        if (drv_hi && drv_lo) both++;
      end
      ph = drv_hi; pl = drv_lo;
      mode = 2'(m); dt_prog = 8'(p);
      req_lo = (c < t_lo_fall);
      req_hi = (c >= t_hi_rise);
    end
    if (m == 3) begin
      if (g < 0) chk("R8 overlap passes", both, -g);
      else begin
        chk("R8 follow gap", hi_rise - lo_fall, g);
        chk("R10 one-cycle latency", hi_rise, t_hi_rise + 1);
      end
    end else begin
      chk(tag_of(m, p, g), hi_rise - lo_fall, e);
      chk("R11 no overlap", both, 0);
    end
    if (hi_fall >= 0) chk("R9 hi-to-lo dead-time", lo_rise - hi_fall, d);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req_hi = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset hi low", int'(drv_hi), 0);
    chk("R1 reset lo low", int'(drv_lo), 0);
    rst_n = 1'b1;
    // R1: counters cleared, so first rise lands on edge 40 after release
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 39) chk("R1 first rise not early", int'(drv_hi), 0);
      if (k == 40) chk("R1 first rise on time", int'(drv_hi), 1);
    end
    for (int i = 0; i < NC; i++) run_case(TM[i], TP[i], TG[i]);
    chk("R1 hi high before reset", int'(drv_hi), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears hi", int'(drv_hi), 0);
    chk("R1 reset keeps lo low", int'(drv_lo), 0);
    rst_n = 1'b1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule